// File: doc/BRIEF.md
# Level Interrupt Mask-and-Cause Controller

This block collects thirty-two level-sensitive interrupt sources and presents them to a host processor as a single cascaded interrupt request. Each source owns one bit in a cause register and one bit in an enable (mask) register. A cause bit is set whenever its source is high. The host clears it by writing a one to that bit position. A line is deliverable only while both its cause bit and its enable bit are set.

The host reaches the two registers through a 32-bit valid/ready register port. Bit n of each register word belongs to line n. The cause register sits at byte offset 0x00 and the enable register at byte offset 0x04. Besides the merged request output, the block reports the lowest-numbered deliverable line through a status port, so the host can service lines in ascending order.

The register port is run by a two-state sequencer. `ST_IDLE` holds `req_ready` high. It takes the `ST_IDLE -> ST_RESP` transition when `req_valid` is seen, and at that edge it performs the write or captures the read word. `ST_RESP` drives `rsp_valid` for one cycle and always takes the `ST_RESP -> ST_IDLE` transition.

Top module: `irq_mask_cause_ctrl`

## Requirements
- R1: After reset the cause and enable registers read as zero, and `irq_out` and `pend_valid` are low.
- R2: A source that is high at a rising clock edge has its cause bit set after that edge. The bit stays set after the source falls, until it is cleared.
- R3: A write to offset 0x00 clears each cause bit whose data bit is one and whose source is low. Cause bits whose data bit is zero are left unchanged.
- R4: If a source is high in the same cycle as a clearing write to its bit, the set wins and the bit stays one.
- R5: A write to offset 0x04 replaces the whole enable register, and a read returns it. Bit n set enables line n. A cause bit whose enable bit is zero affects neither `irq_out` nor the status port.
- R6: `irq_out` is the OR over all lines of cause AND enable. It is registered, so it follows a change in either register one clock later.
- R7: `pend_valid` is high when any line is deliverable. `pend_idx` then gives the lowest-numbered deliverable line. Both are registered with the same one-clock latency as `irq_out`.
- R8: `req_ready` is high exactly in `ST_IDLE`. A request is accepted on the edge where `req_valid` and `req_ready` are both high. `rsp_valid` is high for exactly the one following cycle, with `req_ready` low. For a read, `rsp_rdata` holds the register value at the accepting edge. For a write, `rsp_rdata` is zero.
- R9: Reads of any offset other than 0x00 and 0x04 return zero, and writes to such offsets change no register.
- R10: Writing 0 to offset 0x04 and then 0xFFFFFFFF to offset 0x00, with all sources low, leaves both registers zero, `irq_out` low and `pend_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| irq_src | input | 32 | Level interrupt sources, bit n is line n |
| req_valid | input | 1 | Register request present |
| req_ready | output | 1 | Sequencer can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 4 | Byte offset of the register |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response cycle |
| rsp_rdata | output | 32 | Read data (zero for writes) |
| irq_out | output | 1 | Cascaded interrupt request to the host |
| pend_valid | output | 1 | Some line is deliverable |
| pend_idx | output | 5 | Lowest deliverable line number |

## Verification
Some rules are checked by the embedded assertions on every cycle. These are that an active source always leaves its cause bit set, that a clearing write empties the bits whose sources are low, that the enable register moves only on its own write, and that the sequencer's response lasts one cycle with ready low. They also cover that `irq_out` and `pend_idx` follow the previous cycle's deliverable vector, with no lower deliverable line than the reported one. Other behaviour can only be shown by the bench's scenarios. This includes the read data returned for each offset, unmapped offsets having no effect, the set-over-clear collision seen from the host side, the quiesce sequence, and the reporting order when several lines are pending under different enable patterns.

// File: rtl/pic_pkg.sv
package pic_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } bus_state_e;

    localparam int CAUSE_OFS = 0;
    localparam int ENABLE_OFS = 4;
endpackage

// File: rtl/pic_bus_fsm.sv
module pic_bus_fsm
    import pic_pkg::*;
#(
    parameter int ADDR_W  = 4,
    parameter int DATA_W  = 32,
    parameter int N_LINES = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [DATA_W-1:0]  req_wdata,
    input  logic [N_LINES-1:0] cause_q,
    input  logic [N_LINES-1:0] enable_q,
    output logic               req_ready,
    output logic [N_LINES-1:0] cause_clr,
    output logic               enable_we,
    output logic [N_LINES-1:0] enable_wdata,
    output logic               rsp_valid,
    output logic [DATA_W-1:0]  rsp_rdata
);
    bus_state_e state_q, state_d;
    logic accept, hit_cause, hit_enable;
    logic [DATA_W-1:0] read_word;

    assign accept     = req_valid && (state_q == ST_IDLE);
    assign hit_cause  = (req_addr == ADDR_W'(CAUSE_OFS));
    assign hit_enable = (req_addr == ADDR_W'(ENABLE_OFS));

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid) state_d = ST_RESP;
            ST_RESP: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        req_ready    = (state_q == ST_IDLE);
        rsp_valid    = (state_q == ST_RESP);
        cause_clr    = (accept && req_write && hit_cause) ? req_wdata[N_LINES-1:0] : '0;
        enable_we    = accept && req_write && hit_enable;
        enable_wdata = req_wdata[N_LINES-1:0];
        if (hit_cause)       read_word = DATA_W'(cause_q);
        else if (hit_enable) read_word = DATA_W'(enable_q);
        else                 read_word = '0;
    end

    always_ff @(posedge clk) begin
        if (rst)         rsp_rdata <= '0;
        else if (accept) rsp_rdata <= req_write ? '0 : read_word;
    end

    assert_rsp_single_R8: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);
    assert_ready_low_in_rsp_R8: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> !req_ready);
    assert_accept_leads_rsp_R8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> rsp_valid);
endmodule

// File: rtl/pic_regs.sv
module pic_regs #(
    parameter int N_LINES = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N_LINES-1:0] irq_src,
    input  logic [N_LINES-1:0] cause_clr,
    input  logic               enable_we,
    input  logic [N_LINES-1:0] enable_wdata,
    output logic [N_LINES-1:0] cause_q,
    output logic [N_LINES-1:0] enable_q
);
    // one flop per line; a live source overrides a clear in the same cycle
    for (genvar g = 0; g < N_LINES; g++) begin : g_cause
        always_ff @(posedge clk) begin
            if (rst)               cause_q[g] <= 1'b0;
            else if (irq_src[g])   cause_q[g] <= 1'b1;
            else if (cause_clr[g]) cause_q[g] <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)            enable_q <= '0;
        else if (enable_we) enable_q <= enable_wdata;
    end

    assert_source_sets_R4: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((cause_q & $past(irq_src)) == $past(irq_src)));
    assert_clear_quiet_R3: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((cause_q & $past(cause_clr & ~irq_src)) == '0));
    assert_cause_sticky_R2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((($past(cause_q) & ~$past(cause_clr)) & ~cause_q) == '0));
    assert_enable_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !enable_we |=> $stable(enable_q));
endmodule

// File: rtl/pic_lowest_first.sv
module pic_lowest_first #(
    parameter int N_LINES = 32,
    localparam int IDX_W  = $clog2(N_LINES)
) (
    input  logic [N_LINES-1:0] vec,
    output logic               found,
    output logic [IDX_W-1:0]   idx
);
    always_comb begin
        found = |vec;
        idx   = '0;
        for (int i = N_LINES - 1; i >= 0; i--) begin
            if (vec[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/irq_mask_cause_ctrl.sv
module irq_mask_cause_ctrl #(
    parameter int ADDR_W  = 4,
    parameter int DATA_W  = 32,
    parameter int N_LINES = 32,
    localparam int IDX_W  = $clog2(N_LINES)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N_LINES-1:0] irq_src,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic               req_write,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [DATA_W-1:0]  req_wdata,
    output logic               rsp_valid,
    output logic [DATA_W-1:0]  rsp_rdata,
    output logic               irq_out,
    output logic               pend_valid,
    output logic [IDX_W-1:0]   pend_idx
);
    logic [N_LINES-1:0] cause_q, enable_q, cause_clr, enable_wdata, live;
    logic               enable_we, any_live;
    logic [IDX_W-1:0]   low_idx;

    pic_bus_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_LINES(N_LINES)) u_seq (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .cause_q(cause_q), .enable_q(enable_q),
        .req_ready(req_ready), .cause_clr(cause_clr),
        .enable_we(enable_we), .enable_wdata(enable_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
    );

    pic_regs #(.N_LINES(N_LINES)) u_regs (
        .clk(clk), .rst(rst), .irq_src(irq_src),
        .cause_clr(cause_clr), .enable_we(enable_we),
        .enable_wdata(enable_wdata),
        .cause_q(cause_q), .enable_q(enable_q)
    );

    assign live = cause_q & enable_q;

    pic_lowest_first #(.N_LINES(N_LINES)) u_pick (
        .vec(live), .found(any_live), .idx(low_idx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_out    <= 1'b0;
            pend_valid <= 1'b0;
            pend_idx   <= '0;
        end else begin
            irq_out    <= any_live;
            pend_valid <= any_live;
            pend_idx   <= low_idx;
        end
    end

    assert_out_follows_R6: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (irq_out == ($past(cause_q & enable_q) != '0)));
    assert_idx_is_set_R7: assert property (@(posedge clk) disable iff (rst)
        (|live) |=> (pend_valid && $past(live[low_idx])));
    assert_idx_is_lowest_R7: assert property (@(posedge clk) disable iff (rst)
        (|live) |=> (($past(live) & ((N_LINES'(1) << pend_idx) - N_LINES'(1))) == '0));
endmodule

// File: tb/tb_irq_mask_cause_ctrl.sv
`timescale 1ns/1ps
module tb_irq_mask_cause_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] irq_src = '0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [3:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        req_ready, rsp_valid, irq_out, pend_valid;
    logic [31:0] rsp_rdata;
    logic [4:0]  pend_idx;

    int  n_checks = 0, n_fail = 0;
    bit  mon_en = 1'b0, finished = 1'b0;

    always #2 clk = ~clk;

    irq_mask_cause_ctrl dut (
        .clk(clk), .rst(rst), .irq_src(irq_src),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .irq_out(irq_out), .pend_valid(pend_valid), .pend_idx(pend_idx)
    );

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [5:0] lowest(input logic [31:0] v);
        lowest = 6'd32;
        for (int i = 31; i >= 0; i--) if (v[i]) lowest = 6'(i);
    endfunction

    // reference model of the requirements
    logic [31:0] m_cause = '0, m_en = '0, m_rdata = '0;
    logic        m_out = 1'b0, m_busy = 1'b0;
    logic [5:0]  m_low = 6'd32;
    logic        acc;
    logic [31:0] clr;

    always @(posedge clk) begin
        if (rst) begin
            m_cause <= '0; m_en <= '0; m_rdata <= '0;
            m_out <= 1'b0; m_busy <= 1'b0; m_low <= 6'd32;
        end else begin
            acc = req_valid && !m_busy;
            clr = (acc && req_write && req_addr == 4'h0) ? req_wdata : '0;
            m_cause <= (m_cause & ~clr) | irq_src;
            if (acc && req_write && req_addr == 4'h4) m_en <= req_wdata;
            if (acc) m_rdata <= req_write ? '0 :
                                (req_addr == 4'h0) ? m_cause :
                                (req_addr == 4'h4) ? m_en : '0;
            m_busy <= acc;
            m_out  <= (m_cause & m_en) != '0;
            m_low  <= lowest(m_cause & m_en);
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (mon_en && !rst) begin
            check(irq_out == m_out, "R6 irq_out", 32'(irq_out), 32'(m_out));
            check(pend_valid == (m_low != 6'd32), "R7 pend_valid",
                  32'(pend_valid), 32'(m_low != 6'd32));
            if (m_low != 6'd32)
                check(pend_idx == m_low[4:0], "R7 pend_idx", 32'(pend_idx), 32'(m_low));
            check(req_ready == !m_busy, "R8 req_ready", 32'(req_ready), 32'(!m_busy));
            check(rsp_valid == m_busy, "R8 rsp_valid", 32'(rsp_valid), 32'(m_busy));
            if (m_busy)
                check(rsp_rdata == m_rdata, "R8 rsp_rdata", rsp_rdata, m_rdata);
        end
    end

    task automatic bus(input bit wr, input logic [3:0] a, input logic [31:0] d,
                       output logic [31:0] rd);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        rd = rsp_rdata;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    logic [31:0] rd;

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        mon_en = 1'b1;
        // R1 reset state
        check(!irq_out && !pend_valid, "R1 outputs", {irq_out, pend_valid}, 0);
        bus(1'b0, 4'h0, 0, rd); check(rd == 0, "R1 cause", rd, 0);
        bus(1'b0, 4'h4, 0, rd); check(rd == 0, "R1 enable", rd, 0);

        // R2 pulse latches, masked line stays silent (R5)
        @(negedge clk); irq_src = 32'h0000_0020;
        @(negedge clk); irq_src = '0;
        idle(2);
        bus(1'b0, 4'h0, 0, rd); check(rd == 32'h20, "R2 sticky cause", rd, 32'h20);
        check(!irq_out, "R5 masked line silent", 32'(irq_out), 0);

        // R5 enable and read back, R7 lowest first
        bus(1'b1, 4'h4, 32'hFFFF_FFFF, rd);
        @(negedge clk); irq_src = 32'h0002_0000;
        @(negedge clk); irq_src = '0;
        idle(2);
        check(pend_valid && pend_idx == 5'd5, "R7 lowest of 5,17", 32'(pend_idx), 5);
        bus(1'b1, 4'h4, 32'h0002_0000, rd);
        idle(1);
        check(pend_idx == 5'd17, "R5 enable selects 17", 32'(pend_idx), 17);
        bus(1'b0, 4'h4, 0, rd); check(rd == 32'h0002_0000, "R5 enable readback", rd, 32'h0002_0000);

        // R3 clear bit 5 only, bit 17 untouched
        bus(1'b1, 4'h0, 32'h20, rd); check(rd == 0, "R8 write rdata", rd, 0);
        bus(1'b0, 4'h0, 0, rd); check(rd == 32'h0002_0000, "R3 clear one bit", rd, 32'h0002_0000);

        // R4 set wins over clear
        @(negedge clk); irq_src = 32'h8;
        bus(1'b1, 4'h0, 32'h8, rd);
        bus(1'b0, 4'h0, 0, rd); check(rd[3] == 1'b1, "R4 set beats clear", 32'(rd[3]), 1);
        irq_src = '0;
        bus(1'b1, 4'h0, 32'h8, rd);
        bus(1'b0, 4'h0, 0, rd); check(rd[3] == 1'b0, "R3 clear after drop", 32'(rd[3]), 0);

        // R9 unmapped offsets
        bus(1'b1, 4'h8, 32'hDEAD_BEEF, rd);
        bus(1'b0, 4'h8, 0, rd); check(rd == 0, "R9 unmapped read", rd, 0);
        bus(1'b0, 4'h4, 0, rd); check(rd == 32'h0002_0000, "R9 enable unchanged", rd, 32'h0002_0000);
        bus(1'b1, 4'hC, 32'hFFFF_FFFF, rd);
        bus(1'b0, 4'h0, 0, rd); check(rd == 32'h0002_0000, "R9 cause unchanged", rd, 32'h0002_0000);

        // constrained random traffic
        for (int it = 0; it < 600; it++) begin
            int op;
            @(negedge clk);
            irq_src = $urandom & $urandom & $urandom;
            op = $urandom_range(0, 5);
            case (op)
                0: bus(1'b1, 4'h4, $urandom, rd);
                1: bus(1'b1, 4'h0, $urandom | $urandom, rd);
                2: bus(1'b0, 4'h0, 0, rd);
                3: bus(1'b0, 4'h4, 0, rd);
                4: bus(1'b0, 4'($urandom_range(0, 15)), 0, rd);
                default: idle($urandom_range(1, 3));
            endcase
        end

        // R10 quiesce
        @(negedge clk); irq_src = '0;
        bus(1'b1, 4'h4, 32'h0, rd);
        bus(1'b1, 4'h0, 32'hFFFF_FFFF, rd);
        idle(2);
        check(!irq_out && !pend_valid, "R10 outputs low", {irq_out, pend_valid}, 0);
        bus(1'b0, 4'h0, 0, rd); check(rd == 0, "R10 cause empty", rd, 0);
        bus(1'b0, 4'h4, 0, rd); check(rd == 0, "R10 enable empty", rd, 0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule